// File: doc/BRIEF.md
# Privilege Mode and Exception Entry Unit

This unit holds the processor state register and its problem-state bit, which selects between supervisor execution and user execution. Each cycle it looks at the decoded-instruction flags (valid, privileged, address), an interrupt request tagged critical or non-critical, two return-from-interrupt strobes (one per class), a software write of the state register and a software write of the vector prefix. From these it picks at most one event.

A privileged instruction presented in user mode is squashed in the same cycle and turned into a program exception. The exception redirects fetch to a handler whose low halfword is fixed at 0x0700 and whose upper bits come from the prefix register. Interrupt entry saves the instruction address and the whole state register into one of two save pairs, chosen by class, and drops to supervisor mode. A return of the matching class restores both.

The squash, exception and redirect outputs are combinational on the cycle of the event. The state and save registers update on the next rising edge.

Top module: `mtu_top`

## Requirements
- R1: The problem-state bit sits at position PR_POS of the state register. A 1 means user mode and a 0 means supervisor mode. `user_mode` always shows this bit.
- R2: After reset the state register, all four save registers and the prefix register are zero, so execution starts in supervisor mode and no redirect is raised.
- R3: A non-critical entry (a non-critical interrupt or a program exception) loads `ins_pc` into save register 0 and the pre-entry state register into save register 1 on the next edge.
- R4: A critical interrupt loads `ins_pc` into save register 2 and the pre-entry state register into save register 3. Save registers 0 and 1 are left unchanged.
- R5: Any entry clears the problem-state bit and keeps every other state bit.
- R6: `ins_vld` and `ins_priv` high while in user mode drive `squash` high in that same cycle. `prog_exc` is also raised unless a critical interrupt is taken in that cycle.
- R7: A program exception redirects to {prefix, 16'h0700}. An interrupt of either class redirects to {prefix, `irq_ofs`}.
- R8: `pfx_we` loads `pfx_wdata` into the prefix register on the next edge. The prefix is zero after reset.
- R9: `ret_nc` restores the state register from save register 1 and redirects to save register 0. `ret_cr` restores from save register 3 and redirects to save register 2.
- R10: When several events arrive in one cycle, only the highest-priority one takes effect. The order is: critical interrupt, program exception, non-critical interrupt, critical return, non-critical return, state write.
- R11: In supervisor mode a privileged instruction is neither squashed nor trapped.
- R12: `msr_we` loads `msr_wdata` into the state register when no higher event is present. With no event at all, the state register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ins_vld | input | 1 | Decoded instruction present |
| ins_priv | input | 1 | Decoded instruction is privileged |
| ins_pc | input | AW | Address of the current instruction |
| irq_vld | input | 1 | Interrupt request |
| irq_crit | input | 1 | Interrupt is critical class |
| irq_ofs | input | 16 | Low halfword of the interrupt handler address |
| ret_nc | input | 1 | Non-critical return strobe |
| ret_cr | input | 1 | Critical return strobe |
| msr_we | input | 1 | State register write strobe |
| msr_wdata | input | MW | State register write data |
| pfx_we | input | 1 | Vector prefix write strobe |
| pfx_wdata | input | AW-16 | Vector prefix write data |
| user_mode | output | 1 | Current problem-state bit |
| msr_q | output | MW | State register |
| srr0_q | output | AW | Non-critical saved address |
| srr1_q | output | MW | Non-critical saved state |
| srr2_q | output | AW | Critical saved address |
| srr3_q | output | MW | Critical saved state |
| prog_exc | output | 1 | Privileged-violation program exception taken |
| squash | output | 1 | Current instruction must not execute |
| redir_vld | output | 1 | Fetch redirect this cycle |
| redir_pc | output | AW | Redirect target |

## Verification
The bench builds the unit with AW=24, MW=16 and PR_POS=14. This leaves an 8-bit prefix, which keeps the computed redirect targets easy to tell apart from the fixed halfword. With this configuration the bench can sweep every combination of the six control strobes in both modes, 128 cases in all. Each case starts from freshly loaded save pairs and a case-specific prefix, so every priority collision, each return class and each entry class is checked against values worked out arithmetically.

// File: rtl/mtu_pkg.sv
package mtu_pkg;
  typedef enum logic [2:0] {
    EV_NONE, EV_CIRQ, EV_PROG, EV_NIRQ, EV_CRET, EV_NRET, EV_MSRW
  } mtu_ev_e;
  localparam logic [15:0] PROG_OFS = 16'h0700;
  localparam int NPAIR = 2;
endpackage

// File: rtl/mtu_arb.sv
module mtu_arb
  import mtu_pkg::*;
(
  input  logic    irq_vld,
  input  logic    irq_crit,
  input  logic    viol,
  input  logic    ret_cr,
  input  logic    ret_nc,
  input  logic    msr_we,
  output mtu_ev_e ev
);
  always_comb begin
    if (irq_vld && irq_crit)  ev = EV_CIRQ;
    else if (viol)            ev = EV_PROG;
    else if (irq_vld)         ev = EV_NIRQ;
    else if (ret_cr)          ev = EV_CRET;
    else if (ret_nc)          ev = EV_NRET;
    else if (msr_we)          ev = EV_MSRW;
    else                      ev = EV_NONE;
  end
endmodule

// File: rtl/mtu_bank.sv
module mtu_bank
  import mtu_pkg::*;
#(
  parameter int AW = 32,
  parameter int MW = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPAIR-1:0]           save_en,
  input  logic [AW-1:0]              save_pc,
  input  logic [MW-1:0]              save_st,
  output logic [NPAIR-1:0][AW-1:0]   pc_q,
  output logic [NPAIR-1:0][MW-1:0]   st_q
);
  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    logic [AW-1:0] pc_nx;
    logic [MW-1:0] st_nx;

    always_comb begin
      pc_nx = pc_q[g];
      st_nx = st_q[g];
      if (save_en[g]) begin
        pc_nx = save_pc;
        st_nx = save_st;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pc_q[g] <= '0;
        st_q[g] <= '0;
      end else if (save_en[g]) begin
        pc_q[g] <= pc_nx;
        st_q[g] <= st_nx;
      end
    end

    // R3 (g=0) and R4 (g=1): saved pair captures address and state
    a_r3_pair_capture: assert property (@(posedge clk) disable iff (!rst_n)
      save_en[g] |=> (st_q[g] == $past(save_st)) && (pc_q[g] == $past(save_pc)));
    // R4: a pair not selected keeps its contents
    a_r4_pair_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !save_en[g] |=> $stable(st_q[g]) && $stable(pc_q[g]));
  end
endmodule

// File: rtl/mtu_top.sv
module mtu_top
  import mtu_pkg::*;
#(
  parameter int AW     = 32,
  parameter int MW     = 32,
  parameter int PR_POS = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ins_vld,
  input  logic            ins_priv,
  input  logic [AW-1:0]   ins_pc,
  input  logic            irq_vld,
  input  logic            irq_crit,
  input  logic [15:0]     irq_ofs,
  input  logic            ret_nc,
  input  logic            ret_cr,
  input  logic            msr_we,
  input  logic [MW-1:0]   msr_wdata,
  input  logic            pfx_we,
  input  logic [AW-17:0]  pfx_wdata,
  output logic            user_mode,
  output logic [MW-1:0]   msr_q,
  output logic [AW-1:0]   srr0_q,
  output logic [MW-1:0]   srr1_q,
  output logic [AW-1:0]   srr2_q,
  output logic [MW-1:0]   srr3_q,
  output logic            prog_exc,
  output logic            squash,
  output logic            redir_vld,
  output logic [AW-1:0]   redir_pc
);
  localparam int PW = AW - 16;
  localparam logic [MW-1:0] PR_MASK = MW'(1) << PR_POS;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  logic [MW-1:0] msr_r, msr_nx;
  logic          msr_en;
  logic [PW-1:0] pfx_r, pfx_nx;
  logic          viol;
  mtu_ev_e       ev;
  logic [NPAIR-1:0]         save_en;
  logic [NPAIR-1:0][AW-1:0] bank_pc;
  logic [NPAIR-1:0][MW-1:0] bank_st;

  assign viol = ins_vld && ins_priv && msr_r[PR_POS];

  mtu_arb u_arb (
    .irq_vld (irq_vld),
    .irq_crit(irq_crit),
    .viol    (viol),
    .ret_cr  (ret_cr),
    .ret_nc  (ret_nc),
    .msr_we  (msr_we),
    .ev      (ev)
  );

  assign save_en[0] = (ev == EV_PROG) || (ev == EV_NIRQ);
  assign save_en[1] = (ev == EV_CIRQ);

  mtu_bank #(.AW(AW), .MW(MW)) u_bank (
    .clk    (clk),
    .rst_n  (rst_i),
    .save_en(save_en),
    .save_pc(ins_pc),
    .save_st(msr_r),
    .pc_q   (bank_pc),
    .st_q   (bank_st)
  );

  // state register next value
  always_comb begin
    msr_nx = msr_r;
    unique case (ev)
      EV_CIRQ, EV_PROG, EV_NIRQ: msr_nx = msr_r & ~PR_MASK;
      EV_CRET:                   msr_nx = bank_st[1];
      EV_NRET:                   msr_nx = bank_st[0];
      EV_MSRW:                   msr_nx = msr_wdata;
      default:                   msr_nx = msr_r;
    endcase
  end
  assign msr_en = (ev != EV_NONE);

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)      msr_r <= '0;
    else if (msr_en) msr_r <= msr_nx;
  end

  // vector prefix register
  always_comb pfx_nx = pfx_we ? pfx_wdata : pfx_r;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)      pfx_r <= '0;
    else if (pfx_we) pfx_r <= pfx_nx;
  end

  // redirect
  always_comb begin
    redir_vld = 1'b1;
    redir_pc  = '0;
    unique case (ev)
      EV_CIRQ, EV_NIRQ: redir_pc = {pfx_r, irq_ofs};
      EV_PROG:          redir_pc = {pfx_r, PROG_OFS};
      EV_CRET:          redir_pc = bank_pc[1];
      EV_NRET:          redir_pc = bank_pc[0];
      default:          redir_vld = 1'b0;
    endcase
  end

  assign squash    = viol;
  assign prog_exc  = (ev == EV_PROG);
  assign user_mode = msr_r[PR_POS];
  assign msr_q     = msr_r;
  assign srr0_q    = bank_pc[0];
  assign srr1_q    = bank_st[0];
  assign srr2_q    = bank_pc[1];
  assign srr3_q    = bank_st[1];

  // R5: entry lands in supervisor mode, other bits kept
  a_r5_entry_super: assert property (@(posedge clk) disable iff (!rst_i)
    (prog_exc || irq_vld) |=> !user_mode &&
      ((msr_q & ~PR_MASK) == ($past(msr_q) & ~PR_MASK)));
  // R6: user-mode privileged instruction is squashed
  a_r6_user_trap: assert property (@(posedge clk) disable iff (!rst_i)
    (ins_vld && ins_priv && user_mode) |-> squash);
  // R11: supervisor mode never traps
  a_r11_super_free: assert property (@(posedge clk) disable iff (!rst_i)
    !user_mode |-> !squash && !prog_exc);
  // R7: program exception vector halfword
  a_r7_prog_vector: assert property (@(posedge clk) disable iff (!rst_i)
    prog_exc |-> redir_vld && (redir_pc[15:0] == 16'h0700));
  // R10: critical interrupt outranks the program exception
  a_r10_crit_first: assert property (@(posedge clk) disable iff (!rst_i)
    (irq_vld && irq_crit) |-> !prog_exc && redir_vld && (redir_pc[15:0] == irq_ofs));
  // R9: uncontested non-critical return restores the state
  a_r9_nc_return: assert property (@(posedge clk) disable iff (!rst_i)
    (ret_nc && !ret_cr && !irq_vld && !squash) |=> (msr_q == $past(srr1_q)));
endmodule

// File: tb/sim_mtu_top.sv
module sim_mtu_top;
  localparam int AW = 24;
  localparam int MW = 16;
  localparam int PR = 14;
  localparam int PW = AW - 16;
  localparam logic [MW-1:0] PRM = MW'(1) << PR;

  logic clk = 1'b0;
  logic rst_n;
  logic ins_vld, ins_priv, irq_vld, irq_crit, ret_nc, ret_cr, msr_we, pfx_we;
  logic [AW-1:0] ins_pc;
  logic [15:0]   irq_ofs;
  logic [MW-1:0] msr_wdata;
  logic [PW-1:0] pfx_wdata;
  logic user_mode, prog_exc, squash, redir_vld;
  logic [MW-1:0] msr_q, srr1_q, srr3_q;
  logic [AW-1:0] srr0_q, srr2_q, redir_pc;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  mtu_top #(.AW(AW), .MW(MW), .PR_POS(PR)) u0 (
    .clk(clk), .rst_n(rst_n), .ins_vld(ins_vld), .ins_priv(ins_priv),
    .ins_pc(ins_pc), .irq_vld(irq_vld), .irq_crit(irq_crit), .irq_ofs(irq_ofs),
    .ret_nc(ret_nc), .ret_cr(ret_cr), .msr_we(msr_we), .msr_wdata(msr_wdata),
    .pfx_we(pfx_we), .pfx_wdata(pfx_wdata), .user_mode(user_mode),
    .msr_q(msr_q), .srr0_q(srr0_q), .srr1_q(srr1_q), .srr2_q(srr2_q),
    .srr3_q(srr3_q), .prog_exc(prog_exc), .squash(squash),
    .redir_vld(redir_vld), .redir_pc(redir_pc)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    ins_vld = 0; ins_priv = 0; irq_vld = 0; irq_crit = 0; ret_nc = 0;
    ret_cr = 0; msr_we = 0; pfx_we = 0; ins_pc = '0; irq_ofs = '0;
    msr_wdata = '0; pfx_wdata = '0;
  endtask

  // inputs change on the falling edge, results read 1 ns later
  task automatic tick();
    @(posedge clk); @(negedge clk); idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R2 reset state
    chk("R2 msr", 64'(msr_q), 64'h0);
    chk("R2 user_mode", 64'(user_mode), 64'h0);
    chk("R2 saves", 64'({srr0_q, srr1_q, srr2_q, srr3_q} == '0), 64'h1);
    chk("R2 redir_vld", 64'(redir_vld), 64'h0);
    // R8: prefix resets to zero, seen through the program vector
    @(negedge clk); msr_wdata = PRM; msr_we = 1; tick();
    #1 chk("R1 user_mode set", 64'(user_mode), 64'h1);
    ins_vld = 1; ins_priv = 1; ins_pc = 24'h00ABCD;
    #1 chk("R8 prefix reset", 64'(redir_pc), 64'h000700);
    tick();

    for (int c = 0; c < 128; c++) begin
      logic m, iv, ic, vv, vp, rn, rc, viol;
      logic [PW-1:0] P;
      logic [AW-1:0] P1, P2, P3;
      logic [15:0]   ofs;
      logic [MW-1:0] A, B, C, D, e_msr, e_s1, e_s3;
      logic [AW-1:0] e_s0, e_s2, e_pc;
      logic e_rv, e_px;
      string tag;
      m = c[6]; iv = c[0]; ic = c[1]; vv = c[2]; vp = c[3]; rn = c[4]; rc = c[5];
      P = PW'(8'hA5 ^ c[7:0]);
      P1 = 24'h111100 + AW'(c); P2 = 24'h222200 + AW'(c); P3 = 24'h333300 + AW'(c);
      ofs = 16'h0500 + 16'(c);
      A = 16'h1234 | PRM; B = 16'h0F0F | PRM;
      C = (16'h2468 & ~PRM) | (m ? PRM : '0);
      D = 16'h0C3C;
      // setup: load prefix, non-critical pair, critical pair, then state C
      pfx_we = 1; pfx_wdata = P; msr_we = 1; msr_wdata = A; tick();
      irq_vld = 1; ins_pc = P1; tick();
      msr_we = 1; msr_wdata = B; tick();
      irq_vld = 1; irq_crit = 1; ins_pc = P2; tick();
      msr_we = 1; msr_wdata = C; tick();
      // the case itself
      ins_vld = vv; ins_priv = vp; ins_pc = P3; irq_vld = iv; irq_crit = ic;
      irq_ofs = ofs; ret_nc = rn; ret_cr = rc; msr_we = 1; msr_wdata = D;
      viol = vv && vp && m;
      e_msr = C; e_s0 = P1; e_s1 = A; e_s2 = P2; e_s3 = B;
      e_rv = 1; e_px = 0; e_pc = '0;
      if (iv && ic) begin
        tag = "R4 R10 crit entry"; e_msr = C & ~PRM; e_s2 = P3; e_s3 = C; e_pc = {P, ofs};
      end else if (viol) begin
        tag = "R6 R3 R7 prog exc"; e_px = 1; e_msr = C & ~PRM; e_s0 = P3; e_s1 = C;
        e_pc = {P, 16'h0700};
      end else if (iv) begin
        tag = "R3 R5 R7 nc entry"; e_msr = C & ~PRM; e_s0 = P3; e_s1 = C; e_pc = {P, ofs};
      end else if (rc) begin
        tag = "R9 R10 crit return"; e_msr = B; e_pc = P2;
      end else if (rn) begin
        tag = "R9 nc return"; e_msr = A; e_pc = P1;
      end else begin
        tag = (vv && vp) ? "R11 R12 super priv" : "R12 msr write";
        e_msr = D; e_rv = 0;
      end
      #1;
      chk({tag, " squash R6 R11"}, 64'(squash), 64'(viol));
      chk({tag, " prog_exc"}, 64'(prog_exc), 64'(e_px));
      chk({tag, " redir_vld"}, 64'(redir_vld), 64'(e_rv));
      if (e_rv) chk({tag, " redir_pc"}, 64'(redir_pc), 64'(e_pc));
      tick();
      #1;
      chk({tag, " msr"}, 64'(msr_q), 64'(e_msr));
      chk({tag, " R1 user_mode"}, 64'(user_mode), 64'(e_msr[PR]));
      chk({tag, " srr0/1"}, {16'h0, srr0_q, srr1_q}, {16'h0, e_s0, e_s1});
      chk({tag, " srr2/3"}, {16'h0, srr2_q, srr3_q}, {16'h0, e_s2, e_s3});
    end

    // R12: no event holds the state register
    @(negedge clk); msr_we = 1; msr_wdata = 16'h5A5A; tick();
    tick(); tick();
    #1 chk("R12 hold", 64'(msr_q), 64'h5A5A);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule